// File: doc/BRIEF.md
# Compiler-Hinted Dependency-Mark Issue Queue

This block is the issue stage of a small statically scheduled core. It holds instructions in fetch order and sends up to three of them per cycle to three function lanes. It does not check registers for dependencies at run time. Instead, the compiler splits the stream into runs. Each run opens with a *head* instruction that carries a dependency mark. The unmarked instructions after a head belong to its run and wait until that head has been dispatched. A head waits only while a lane is still held by a long-latency (stall-prone) instruction that carries the same mark. Every other instruction may move ahead of blocked ones, so unrelated work overlaps the stall.

Each entry carries a tag, a head flag, a mark, a group id and a stall-prone flag. A stall-prone instruction holds its lane, together with its mark, until that lane's completion pulse arrives. A branch mispredict removes every queued entry younger than the branch in the cycle it is reported. Tags must be issued by the front end in increasing order, modulo 2^TAG_W.

Top module: `dq_issue_queue`

## Requirements
- R1: An enqueue is accepted only when `enq_ready` is high. `enq_ready` is high when fewer than DEPTH (8) entries are valid and no flush is being reported. An offered entry that is refused never dispatches.
- R2: A head entry (`enq_head`=1) is not dispatched while any lane holds a stall-prone instruction with the same mark. It becomes eligible again in the cycle after that lane's `fu_done` pulse.
- R3: An unmarked entry is dispatchable only once the nearest older head has been dispatched. When a head dispatches, every unmarked entry after it, up to the next head, becomes dispatchable from the next cycle. An unmarked entry enqueued after its head was dispatched, or in the same cycle, is dispatchable at once. An unmarked entry enqueued after reset or after a flush, before any head, is also dispatchable at once.
- R4: Selection is oldest-first among eligible entries. Blocked entries are skipped, so younger eligible entries dispatch ahead of them.
- R5: In one cycle, only entries whose group id equals that of the oldest eligible entry dispatch.
- R6: Lane l (bit l of `disp_valid`, tag at `disp_tag[l*TAG_W +: TAG_W]`) receives nothing while it is stalled. Selected entries go, oldest first, to the free lanes in ascending lane order. No more entries dispatch than there are free lanes.
- R7: Dispatching a stall-prone entry marks its lane as stalled with that entry's mark. A `fu_done` pulse on that lane frees it, and the lane accepts work from the next cycle.
- R8: While `flush_valid` is high, nothing dispatches and every queued entry is removed whose value (tag − `flush_tag`) mod 2^TAG_W lies in 1 .. 2^(TAG_W−1)−1. The other entries keep their order.
- R9: After reset the queue is empty, all lanes are free, `enq_ready` is 1 and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | An instruction is offered |
| enq_ready | output | 1 | Offer is accepted this cycle |
| enq_tag | input | TAG_W | Sequence tag of the offered instruction |
| enq_head | input | 1 | Instruction opens a dependency run |
| enq_mark | input | MARK_W | Dependency mark of the head |
| enq_grp | input | GRP_W | Compiler group id |
| enq_stall | input | 1 | Instruction is long-latency |
| fu_done | input | LANES | Per-lane completion pulse of a stalled instruction |
| flush_valid | input | 1 | Branch mispredict reported |
| flush_tag | input | TAG_W | Tag of the mispredicted branch |
| disp_valid | output | LANES | Lane l receives an instruction this cycle |
| disp_tag | output | LANES*TAG_W | Tags of the dispatched instructions, per lane |

## Verification
A corrupted executable flag or lane status shows up at the dispatch ports in the cycle where the affected entry should first be eligible. It appears either as a tag that appears too early, ahead of its head or while its mark is stalled, or as a queue that stays silent after a `fu_done` pulse. A wrong compaction or flush decision appears a few cycles later. A removed or refused tag then reaches a lane, or a kept one never does, once the blocking head is released. The stimulus therefore releases every blocked run at the end and checks the exact tag-to-lane pattern of each cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;

   typedef struct packed {
      logic vld;    // entry occupied
      logic head;   // opens a dependency run
      logic last;   // most recently enqueued head
      logic exec;   // unmarked entry released by its head
      logic stl;    // long-latency instruction
   } slot_flags_t;

   // true when diff (masked to w bits) is in the forward half-window, non-zero
   function automatic logic is_after(input logic [31:0] diff, input int unsigned w);
      logic [31:0] m;
      m = diff & ((32'd1 << w) - 32'd1);
      return (m != 32'd0) && (m < (32'd1 << (w - 1)));
   endfunction

endpackage

// File: rtl/dq_lanes.sv
module dq_lanes #(
   parameter int LANES  = 3,
   parameter int MARK_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          go,
   input  logic [LANES-1:0]          go_stall,
   input  logic [LANES*MARK_W-1:0]   go_mark,
   input  logic [LANES-1:0]          fu_done,
   output logic [LANES-1:0]          lane_stall,
   output logic [LANES*MARK_W-1:0]   lane_mark
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_stall[l]                   <= 1'b0;
            lane_mark[l*MARK_W +: MARK_W]   <= '0;
         end else if (go[l] && go_stall[l]) begin
            lane_stall[l]                   <= 1'b1;
            lane_mark[l*MARK_W +: MARK_W]   <= go_mark[l*MARK_W +: MARK_W];
         end else if (fu_done[l]) begin
            lane_stall[l]                   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dq_pick.sv
module dq_pick #(
   parameter int DEPTH = 8,
   parameter int LANES = 3,
   parameter int GRP_W = 2,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [DEPTH-1:0]        elig,
   input  logic [DEPTH*GRP_W-1:0]  grp,
   input  logic [LANES-1:0]        lane_free,
   output logic [DEPTH-1:0]        pick,
   output logic [LANES-1:0]        lane_go,
   output logic [LANES*IW-1:0]     lane_src
);

   logic [GRP_W-1:0] lead_grp;
   logic             seen;
   logic             got;
   logic [LANES-1:0] used;

   always_comb begin
      pick     = '0;
      lane_go  = '0;
      lane_src = '0;
      used     = '0;
      seen     = 1'b0;
      lead_grp = '0;
      got      = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i] && !seen) begin
            seen     = 1'b1;
            lead_grp = grp[i*GRP_W +: GRP_W];
         end
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i] && grp[i*GRP_W +: GRP_W] == lead_grp) begin
            got = 1'b0;
            for (int l = 0; l < LANES; l++) begin
               if (lane_free[l] && !used[l] && !got) begin
                  got                   = 1'b1;
                  used[l]               = 1'b1;
                  lane_go[l]            = 1'b1;
                  lane_src[l*IW +: IW]  = IW'(i);
               end
            end
            pick[i] = got;
         end
      end
   end

endmodule

// File: rtl/dq_issue_queue.sv
module dq_issue_queue #(
   parameter int DEPTH  = 8,
   parameter int LANES  = 3,
   parameter int TAG_W  = 5,
   parameter int MARK_W = 2,
   parameter int GRP_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enq_valid,
   output logic                    enq_ready,
   input  logic [TAG_W-1:0]        enq_tag,
   input  logic                    enq_head,
   input  logic [MARK_W-1:0]       enq_mark,
   input  logic [GRP_W-1:0]        enq_grp,
   input  logic                    enq_stall,
   input  logic [LANES-1:0]        fu_done,
   input  logic                    flush_valid,
   input  logic [TAG_W-1:0]        flush_tag,
   output logic [LANES-1:0]        disp_valid,
   output logic [LANES*TAG_W-1:0]  disp_tag
);
   import dq_pkg::*;

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int OW = $clog2(DEPTH + 1);

   if (LANES < 1 || LANES > DEPTH) begin : g_bad_lanes
      $error("dq_issue_queue: LANES must be 1..DEPTH");
   end
   if (TAG_W < $clog2(DEPTH) + 2) begin : g_bad_tag
      $error("dq_issue_queue: TAG_W too narrow for the in-flight window");
   end
   if (MARK_W < 1 || GRP_W < 1) begin : g_bad_fields
      $error("dq_issue_queue: MARK_W and GRP_W must be at least 1");
   end

   slot_flags_t        flg_q  [DEPTH];
   logic [MARK_W-1:0]  mark_q [DEPTH];
   logic [GRP_W-1:0]   grp_q  [DEPTH];
   logic [TAG_W-1:0]   tag_q  [DEPTH];
   logic               live_q;

   slot_flags_t        flg_d  [DEPTH];
   logic [MARK_W-1:0]  mark_d [DEPTH];
   logic [GRP_W-1:0]   grp_d  [DEPTH];
   logic [TAG_W-1:0]   tag_d  [DEPTH];
   logic               live_d;

   logic [DEPTH-1:0]        elig, pick, kill, set_exec;
   logic [DEPTH*GRP_W-1:0]  grp_flat;
   logic [LANES-1:0]        lane_stall, lane_go, go_stall;
   logic [LANES*MARK_W-1:0] lane_mark, go_mark;
   logic [LANES*IW-1:0]     lane_src;
   logic [OW-1:0]           occ;
   logic                    enq_acc, last_iss, run_go;
   slot_flags_t             fcur;
   int                      pos;

   // ---------------- eligibility ----------------
   always_comb begin
      elig     = '0;
      grp_flat = '0;
      kill     = '0;
      occ      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         logic hit;
         hit = 1'b0;
         for (int l = 0; l < LANES; l++)
            if (lane_stall[l] && lane_mark[l*MARK_W +: MARK_W] == mark_q[i]) hit = 1'b1;
         elig[i] = !flush_valid && flg_q[i].vld &&
                   (flg_q[i].head ? !hit : flg_q[i].exec);
         grp_flat[i*GRP_W +: GRP_W] = grp_q[i];
         kill[i] = flush_valid && flg_q[i].vld &&
                   is_after(32'(tag_q[i] - flush_tag), TAG_W);
         occ = occ + OW'(flg_q[i].vld);
      end
   end

   dq_pick #(.DEPTH(DEPTH), .LANES(LANES), .GRP_W(GRP_W)) u_pick (
      .elig      (elig),
      .grp       (grp_flat),
      .lane_free (~lane_stall),
      .pick      (pick),
      .lane_go   (lane_go),
      .lane_src  (lane_src)
   );

   // ---------------- dispatch ----------------
   always_comb begin
      disp_tag = '0;
      go_stall = '0;
      go_mark  = '0;
      for (int l = 0; l < LANES; l++) begin
         disp_tag[l*TAG_W +: TAG_W]   = tag_q[lane_src[l*IW +: IW]];
         go_stall[l]                  = flg_q[lane_src[l*IW +: IW]].stl;
         go_mark[l*MARK_W +: MARK_W]  = mark_q[lane_src[l*IW +: IW]];
      end
   end
   assign disp_valid = lane_go;

   dq_lanes #(.LANES(LANES), .MARK_W(MARK_W)) u_lanes (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (lane_go),
      .go_stall   (go_stall),
      .go_mark    (go_mark),
      .fu_done    (fu_done),
      .lane_stall (lane_stall),
      .lane_mark  (lane_mark)
   );

   // ---------------- run release ----------------
   always_comb begin
      set_exec = '0;
      run_go   = 1'b0;
      last_iss = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (flg_q[i].head) run_go = pick[i];
         else               set_exec[i] = run_go;
         if (pick[i] && flg_q[i].last) last_iss = 1'b1;
      end
   end

   assign enq_ready = !flg_q[DEPTH-1].vld && !flush_valid;
   assign enq_acc   = enq_valid && enq_ready;

   // ---------------- compaction ----------------
   always_comb begin
      pos  = 0;
      fcur = '0;
      for (int i = 0; i < DEPTH; i++) begin
         flg_d[i]  = '0;
         mark_d[i] = '0;
         grp_d[i]  = '0;
         tag_d[i]  = '0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (flg_q[i].vld && !pick[i] && !kill[i] && pos < DEPTH) begin
            fcur      = flg_q[i];
            fcur.exec = fcur.exec | set_exec[i];
            if (flush_valid || (enq_acc && enq_head)) fcur.last = 1'b0;
            flg_d[pos]  = fcur;
            mark_d[pos] = mark_q[i];
            grp_d[pos]  = grp_q[i];
            tag_d[pos]  = tag_q[i];
            pos = pos + 1;
         end
      end
      if (enq_acc && pos < DEPTH) begin
         flg_d[pos].vld  = 1'b1;
         flg_d[pos].head = enq_head;
         flg_d[pos].last = enq_head;
         flg_d[pos].exec = !enq_head && (live_q || last_iss);
         flg_d[pos].stl  = enq_stall;
         mark_d[pos]     = enq_mark;
         grp_d[pos]      = enq_grp;
         tag_d[pos]      = enq_tag;
      end
      if (flush_valid)              live_d = 1'b1;
      else if (enq_acc && enq_head) live_d = 1'b0;
      else if (last_iss)            live_d = 1'b1;
      else                          live_d = live_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            flg_q[i]  <= '0;
            mark_q[i] <= '0;
            grp_q[i]  <= '0;
            tag_q[i]  <= '0;
         end
      end else begin
         live_q <= live_d;
         for (int i = 0; i < DEPTH; i++) begin
            flg_q[i]  <= flg_d[i];
            mark_q[i] <= mark_d[i];
            grp_q[i]  <= grp_d[i];
            tag_q[i]  <= tag_d[i];
         end
      end
   end

endmodule

// File: rtl/dq_issue_queue_chk.sv
module dq_issue_queue_chk #(
   parameter int DEPTH = 8,
   parameter int LANES = 3,
   localparam int OW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_valid,
   input logic             enq_ready,
   input logic [LANES-1:0] disp_valid,
   input logic [LANES-1:0] lane_stall,
   input logic [OW-1:0]    occ
);

   p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   p_occ_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= int'($past(occ)) + 1);

   p_no_enq_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(occ) == DEPTH) |-> !enq_ready);

   p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> (disp_valid == '0));

   p_flush_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (int'(occ) <= int'($past(occ))));

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      p_stalled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lane_stall[l] |-> !disp_valid[l]);

      p_stall_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lane_stall[l]) |-> $past(disp_valid[l]));
   end

endmodule

bind dq_issue_queue dq_issue_queue_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_valid (flush_valid),
   .enq_ready   (enq_ready),
   .disp_valid  (disp_valid),
   .lane_stall  (lane_stall),
   .occ         (occ)
);

// File: tb/sim_dq_issue_queue.sv
module sim_dq_issue_queue;

   localparam int LANES = 3;
   localparam int TW    = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enq_valid = 1'b0, enq_head = 1'b0, enq_stall = 1'b0;
   logic [TW-1:0]    enq_tag = '0, flush_tag = '0;
   logic [1:0]       enq_mark = '0, enq_grp = '0;
   logic [LANES-1:0] fu_done = '0;
   logic             flush_valid = 1'b0;
   logic             enq_ready;
   logic [LANES-1:0] disp_valid;
   logic [LANES*TW-1:0] disp_tag;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dq_issue_queue u0 (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
      .enq_tag(enq_tag), .enq_head(enq_head), .enq_mark(enq_mark),
      .enq_grp(enq_grp), .enq_stall(enq_stall), .fu_done(fu_done),
      .flush_valid(flush_valid), .flush_tag(flush_tag),
      .disp_valid(disp_valid), .disp_tag(disp_tag)
   );

   typedef struct packed {
      logic       ev;
      logic       hd;
      logic [1:0] mk;
      logic [1:0] gp;
      logic       st;
      logic [4:0] tg;
      logic [2:0] dn;
      logic [2:0] xv;
      logic [4:0] x0;
      logic [4:0] x1;
      logic [4:0] x2;
   } vec_t;

   // per row: inputs for one cycle, and the dispatch expected in that cycle
   localparam vec_t TBL [19] = '{
      '{1'b1,1'b1,2'd1,2'd0,1'b1,5'd0, 3'b000,3'b000,5'd0,5'd0,5'd0},   // R9 empty
      '{1'b1,1'b0,2'd0,2'd0,1'b0,5'd1, 3'b000,3'b001,5'd0,5'd0,5'd0},   // R2 head goes
      '{1'b1,1'b1,2'd1,2'd1,1'b0,5'd2, 3'b000,3'b010,5'd0,5'd1,5'd0},   // R6 lane0 stalled
      '{1'b1,1'b0,2'd0,2'd1,1'b0,5'd3, 3'b000,3'b000,5'd0,5'd0,5'd0},   // R2 blocked
      '{1'b1,1'b1,2'd2,2'd1,1'b0,5'd4, 3'b000,3'b000,5'd0,5'd0,5'd0},   // R3 follower waits
      '{1'b1,1'b0,2'd0,2'd1,1'b0,5'd5, 3'b000,3'b010,5'd0,5'd4,5'd0},   // R4 skip blocked
      '{1'b1,1'b0,2'd0,2'd2,1'b0,5'd6, 3'b000,3'b010,5'd0,5'd5,5'd0},   // R3 released
      '{1'b0,1'b0,2'd0,2'd0,1'b0,5'd0, 3'b001,3'b010,5'd0,5'd6,5'd0},   // R3 live run
      '{1'b0,1'b0,2'd0,2'd0,1'b0,5'd0, 3'b000,3'b001,5'd2,5'd0,5'd0},   // R7 after done
      '{1'b0,1'b0,2'd0,2'd0,1'b0,5'd0, 3'b000,3'b001,5'd3,5'd0,5'd0},   // R3 follower
      '{1'b1,1'b1,2'd1,2'd3,1'b1,5'd7, 3'b000,3'b000,5'd0,5'd0,5'd0},
      '{1'b1,1'b1,2'd1,2'd2,1'b0,5'd8, 3'b000,3'b001,5'd7,5'd0,5'd0},   // R7
      '{1'b1,1'b0,2'd0,2'd2,1'b0,5'd9, 3'b000,3'b000,5'd0,5'd0,5'd0},   // R2
      '{1'b1,1'b0,2'd0,2'd2,1'b0,5'd10,3'b000,3'b000,5'd0,5'd0,5'd0},
      '{1'b1,1'b0,2'd0,2'd3,1'b0,5'd11,3'b000,3'b000,5'd0,5'd0,5'd0},
      '{1'b1,1'b0,2'd0,2'd3,1'b0,5'd12,3'b001,3'b000,5'd0,5'd0,5'd0},   // R7 same-cycle
      '{1'b1,1'b0,2'd0,2'd3,1'b0,5'd13,3'b000,3'b001,5'd8,5'd0,5'd0},   // R2 release
      '{1'b0,1'b0,2'd0,2'd0,1'b0,5'd0, 3'b000,3'b011,5'd9,5'd10,5'd0},  // R5 group cut
      '{1'b0,1'b0,2'd0,2'd0,1'b0,5'd0, 3'b000,3'b111,5'd11,5'd12,5'd13} // R6 three wide
   };

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic chk1(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_disp(input string req, input logic [2:0] xv,
                           input logic [4:0] x0, input logic [4:0] x1, input logic [4:0] x2);
      logic [4:0] xt [3];
      xt[0] = x0; xt[1] = x1; xt[2] = x2;
      chk1({req, " disp_valid"}, 32'(disp_valid), 32'(xv));
      for (int l = 0; l < LANES; l++)
         if (xv[l]) chk1({req, " disp_tag"}, 32'(disp_tag[l*TW +: TW]), 32'(xt[l]));
   endtask

   task automatic drive(input logic ev, input logic hd, input logic [1:0] mk,
                        input logic [1:0] gp, input logic st, input logic [4:0] tg,
                        input logic [2:0] dn);
      enq_valid = ev; enq_head = hd; enq_mark = mk; enq_grp = gp;
      enq_stall = st; enq_tag = tg; fu_done = dn;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk1("R9 enq_ready", 32'(enq_ready), 32'd1);
      chk1("R9 disp_valid", 32'(disp_valid), 32'd0);

      foreach (TBL[k]) begin
         @(negedge clk);
         drive(TBL[k].ev, TBL[k].hd, TBL[k].mk, TBL[k].gp, TBL[k].st, TBL[k].tg, TBL[k].dn);
         #1;
         chk_disp($sformatf("row%0d R2/R3/R4/R5/R6/R7", k), TBL[k].xv, TBL[k].x0, TBL[k].x1, TBL[k].x2);
      end

      // fill, refusal and flush (R1, R8)
      @(negedge clk); drive(1, 1, 2'd2, 2'd0, 1, 5'd14, 3'b000); #1;
      chk_disp("R7 stall head", 3'b000, 0, 0, 0);
      @(negedge clk); drive(1, 1, 2'd2, 2'd1, 0, 5'd15, 3'b000); #1;
      chk_disp("R7 stall head goes", 3'b001, 5'd14, 0, 0);
      for (int t = 16; t <= 22; t++) begin
         @(negedge clk); drive(1, 0, 2'd0, 2'd1, 0, 5'(t), 3'b000); #1;
         chk_disp("R2 blocked fill", 3'b000, 0, 0, 0);
      end
      @(negedge clk); drive(1, 0, 2'd0, 2'd1, 0, 5'd23, 3'b000); #1;
      chk1("R1 full refuses", 32'(enq_ready), 32'd0);
      chk_disp("R1 full", 3'b000, 0, 0, 0);
      @(negedge clk); drive(0, 0, 2'd0, 2'd0, 0, 5'd0, 3'b000);
      flush_valid = 1'b1; flush_tag = 5'd18; #1;
      chk1("R1 flush blocks enqueue", 32'(enq_ready), 32'd0);
      chk_disp("R8 no dispatch in flush", 3'b000, 0, 0, 0);
      @(negedge clk); flush_valid = 1'b0; drive(0, 0, 2'd0, 2'd0, 0, 5'd0, 3'b001); #1;
      chk1("R8 room after flush", 32'(enq_ready), 32'd1);
      chk_disp("R7 done same cycle", 3'b000, 0, 0, 0);
      @(negedge clk); drive(0, 0, 2'd0, 2'd0, 0, 5'd0, 3'b000); #1;
      chk_disp("R7 head after done", 3'b001, 5'd15, 0, 0);
      @(negedge clk); #1;
      chk_disp("R8 older kept", 3'b111, 5'd16, 5'd17, 5'd18);
      @(negedge clk); #1;
      chk_disp("R8 younger removed R1 refused", 3'b000, 0, 0, 0);

      finish_run();
   end

endmodule